// File: doc/BRIEF.md
# Test Line Pattern Generator

This block draws one repeating video test line as a digital luminance stream. Each line begins with a sync pulse at sync-tip level. Two white bars follow, and the rest of the line is black. The same line is drawn again and again, so a display shows the pattern as two vertical bars. Downstream logic uses it as the video source for a modulator whenever the test-pattern mode is selected.

While `tp_en` is high, the block does three things:

- It counts pattern positions.
- It reports the level of the current position as a two-bit code.
- It drives the matching sample value on `video_out`.

While `tp_en` is low, the live video input passes through to `video_out`, delayed by one register. The position counter is held at zero, so the next enable always starts with a complete sync pulse.

One pattern position lasts `TICK_DIV` clocks. By default a line is 64 positions long, which is 64 µs at a 1 MHz position rate. Every output is registered, so the value for a position appears one clock after the state that selects it.

Top module: `test_line_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `level_code` = 2'b01, `video_out` = 0 and `line_start` = 0, whatever `tp_en` and `live_video` are. The counter is held at position 0.
- R2: Count j clock edges from the first edge at which `tp_en` is sampled high with `rst` low, starting with that edge as j = 0. After edge j, `line_start` is 1 exactly when j is a multiple of LINE_LEN*TICK_DIV, and 0 otherwise. The output shows position p = (j / TICK_DIV) mod LINE_LEN.
- R3: Positions 0 to 4 give `level_code` 2'b00 (sync) and `video_out` = SYNC_VAL.
- R4: Positions 20 to 29 and 40 to 49 give `level_code` 2'b11 (white) and `video_out` = WHITE_VAL.
- R5: Positions 5 to 19, 30 to 39 and 50 to 63 give `level_code` 2'b01 (black) and `video_out` = BLACK_VAL.
- R6: Every line repeats the same sequence of positions exactly.
- R7: While enabled, `live_video` has no effect on `video_out`.
- R8: After an edge at which `tp_en` is low, `level_code` is 2'b01 and `line_start` is 0. `video_out` equals the `live_video` value sampled at that edge.
- R9: When `tp_en` goes high again after being low, even in the middle of a line, the pattern restarts at position 0 with a `line_start` pulse and a full sync pulse.
- R10: `level_code` never takes the value 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| tp_en | input | 1 | Test-pattern mode select |
| live_video | input | SAMPLE_W | Live video samples passed through when the mode is off |
| level_code | output | 2 | Level of the current position: 00 sync, 01 black, 11 white |
| video_out | output | SAMPLE_W | Pattern sample value or delayed live video |
| line_start | output | 1 | One-clock strobe at position 0 of each line |

## Verification
The bench builds the block with TICK_DIV = 2 and keeps the default 64-position line and 8-bit samples. A divider of 2 brings two things within reach:

- The prescaler branch of the design.
- The case where each position holds for two clocks, so a line lasts 128 clocks.

The bench follows three full lines at that rate and checks that `line_start` is spaced 128 clocks apart. It also checks every bar edge at both of its clocks. A re-enable in the middle of a white bar shows that a restart clears both the position counter and the prescaler phase.

// File: rtl/tlg_pkg.sv
package tlg_pkg;

  typedef enum logic [1:0] {
    LVL_SYNC  = 2'b00,
    LVL_BLACK = 2'b01,
    LVL_WHITE = 2'b11
  } tlg_level_e;

endpackage

// File: rtl/tlg_tick_gen.sv
module tlg_tick_gen #(
  parameter int TICK_DIV = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick,
  output logic phase_zero
);

  generate
    if (TICK_DIV == 1) begin : g_direct
      assign tick       = run;
      assign phase_zero = 1'b1;
    end else begin : g_prescale
      localparam int PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

      logic [PW-1:0] phase_q;

      always_ff @(posedge clk) begin
        if (rst || !run) begin
          phase_q <= '0;
        end else if (phase_q == LAST) begin
          phase_q <= '0;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end

      assign tick       = run && (phase_q == LAST);
      assign phase_zero = (phase_q == '0);
    end
  endgenerate

endmodule

// File: rtl/tlg_pos_counter.sv
module tlg_pos_counter #(
  parameter int LINE_LEN = 64,
  localparam int POS_W = $clog2(LINE_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  output logic [POS_W-1:0] pos
);

  localparam logic [POS_W-1:0] LAST = POS_W'(LINE_LEN - 1);

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pos_q <= '0;
    end else if (tick) begin
      if (pos_q == LAST) begin
        pos_q <= '0;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign pos = pos_q;

endmodule

// File: rtl/tlg_level_map.sv
module tlg_level_map
  import tlg_pkg::*;
#(
  parameter int LINE_LEN   = 64,
  parameter int SYNC_LEN   = 5,
  parameter int BAR0_START = 20,
  parameter int BAR1_START = 40,
  parameter int BAR_WIDTH  = 10,
  localparam int POS_W = $clog2(LINE_LEN),
  localparam int NUM_BARS = 2
) (
  input  logic [POS_W-1:0] pos,
  output tlg_level_e       level
);

  logic [NUM_BARS-1:0] in_bar;
  logic                in_sync;
  int                  pos_i;

  assign pos_i   = int'(pos);
  assign in_sync = (pos_i < SYNC_LEN);

  generate
    for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
      localparam int START = (b == 0) ? BAR0_START : BAR1_START;
      assign in_bar[b] = (pos_i >= START) && (pos_i < START + BAR_WIDTH);
    end
  endgenerate

  always_comb begin
    if (in_sync) begin
      level = LVL_SYNC;
    end else if (|in_bar) begin
      level = LVL_WHITE;
    end else begin
      level = LVL_BLACK;
    end
  end

endmodule

// File: rtl/tlg_out_stage.sv
module tlg_out_stage
  import tlg_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter logic [SAMPLE_W-1:0] SYNC_VAL  = '0,
  parameter logic [SAMPLE_W-1:0] BLACK_VAL = SAMPLE_W'(60),
  parameter logic [SAMPLE_W-1:0] WHITE_VAL = SAMPLE_W'(200)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  tlg_level_e          level,
  input  logic                at_start,
  input  logic [SAMPLE_W-1:0] live_video,
  output logic [1:0]          level_code,
  output logic [SAMPLE_W-1:0] video_out,
  output logic                line_start
);

  logic [SAMPLE_W-1:0] pat_sample;

  always_comb begin
    unique case (level)
      LVL_SYNC:  pat_sample = SYNC_VAL;
      LVL_WHITE: pat_sample = WHITE_VAL;
      default:   pat_sample = BLACK_VAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_code <= LVL_BLACK;
      video_out  <= '0;
      line_start <= 1'b0;
    end else if (run) begin
      level_code <= level;
      video_out  <= pat_sample;
      line_start <= at_start;
    end else begin
      level_code <= LVL_BLACK;
      video_out  <= live_video;
      line_start <= 1'b0;
    end
  end

endmodule

// File: rtl/test_line_gen.sv
module test_line_gen
  import tlg_pkg::*;
#(
  parameter int SAMPLE_W   = 8,
  parameter int TICK_DIV   = 1,
  parameter int LINE_LEN   = 64,
  parameter int SYNC_LEN   = 5,
  parameter int BAR0_START = 20,
  parameter int BAR1_START = 40,
  parameter int BAR_WIDTH  = 10,
  parameter logic [SAMPLE_W-1:0] SYNC_VAL  = '0,
  parameter logic [SAMPLE_W-1:0] BLACK_VAL = SAMPLE_W'(60),
  parameter logic [SAMPLE_W-1:0] WHITE_VAL = SAMPLE_W'(200)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tp_en,
  input  logic [SAMPLE_W-1:0] live_video,
  output logic [1:0]          level_code,
  output logic [SAMPLE_W-1:0] video_out,
  output logic                line_start
);

  localparam int POS_W = $clog2(LINE_LEN);

  logic             tick;
  logic             phase_zero;
  logic [POS_W-1:0] pos;
  tlg_level_e       level;
  logic             at_start;

  tlg_tick_gen #(
    .TICK_DIV(TICK_DIV)
  ) u_tick (
    .clk       (clk),
    .rst       (rst),
    .run       (tp_en),
    .tick      (tick),
    .phase_zero(phase_zero)
  );

  tlg_pos_counter #(
    .LINE_LEN(LINE_LEN)
  ) u_pos (
    .clk (clk),
    .rst (rst),
    .run (tp_en),
    .tick(tick),
    .pos (pos)
  );

  tlg_level_map #(
    .LINE_LEN  (LINE_LEN),
    .SYNC_LEN  (SYNC_LEN),
    .BAR0_START(BAR0_START),
    .BAR1_START(BAR1_START),
    .BAR_WIDTH (BAR_WIDTH)
  ) u_map (
    .pos  (pos),
    .level(level)
  );

  assign at_start = (pos == '0) && phase_zero;

  tlg_out_stage #(
    .SAMPLE_W (SAMPLE_W),
    .SYNC_VAL (SYNC_VAL),
    .BLACK_VAL(BLACK_VAL),
    .WHITE_VAL(WHITE_VAL)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .run       (tp_en),
    .level     (level),
    .at_start  (at_start),
    .live_video(live_video),
    .level_code(level_code),
    .video_out (video_out),
    .line_start(line_start)
  );

endmodule

// File: rtl/tlg_chk.sv
module tlg_chk #(
  parameter int SAMPLE_W = 8,
  parameter int TICK_DIV = 1,
  parameter int LINE_LEN = 64,
  parameter logic [SAMPLE_W-1:0] SYNC_VAL = '0
) (
  input logic                clk,
  input logic                rst,
  input logic                tp_en,
  input logic [SAMPLE_W-1:0] live_video,
  input logic [1:0]          level_code,
  input logic [SAMPLE_W-1:0] video_out,
  input logic                line_start
);

  // R10
  code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    level_code != 2'b10);

  // R3
  start_is_sync_chk: assert property (@(posedge clk) disable iff (rst)
    line_start |-> (level_code == 2'b00 && video_out == SYNC_VAL));

  // R8
  off_black_chk: assert property (@(posedge clk) disable iff (rst)
    !tp_en |=> (level_code == 2'b01 && !line_start));

  // R8
  off_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !tp_en |=> (video_out == $past(live_video)));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tp_en) |=> line_start);

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !line_start);

endmodule

bind test_line_gen tlg_chk #(
  .SAMPLE_W(SAMPLE_W),
  .TICK_DIV(TICK_DIV),
  .LINE_LEN(LINE_LEN),
  .SYNC_VAL(SYNC_VAL)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tp_en     (tp_en),
  .live_video(live_video),
  .level_code(level_code),
  .video_out (video_out),
  .line_start(line_start)
);

// File: tb/sim_test_line_gen.sv
`timescale 1ns/1ps
module sim_test_line_gen;

  localparam int W        = 8;
  localparam int DIV      = 2;
  localparam int LEN      = 64;
  localparam logic [W-1:0] SV = 8'd0;
  localparam logic [W-1:0] BV = 8'd60;
  localparam logic [W-1:0] WV = 8'd200;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tp_en = 1'b0;
  logic [W-1:0] live_video = '0;
  logic [1:0]   level_code;
  logic [W-1:0] video_out;
  logic         line_start;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  test_line_gen #(
    .SAMPLE_W (W),
    .TICK_DIV (DIV),
    .LINE_LEN (LEN),
    .SYNC_VAL (SV),
    .BLACK_VAL(BV),
    .WHITE_VAL(WV)
  ) u0 (
    .clk       (clk),
    .rst       (rst),
    .tp_en     (tp_en),
    .live_video(live_video),
    .level_code(level_code),
    .video_out (video_out),
    .line_start(line_start)
  );

  function automatic logic [1:0] exp_code(int p);
    if (p < 5) return 2'b00;
    if ((p >= 20 && p < 30) || (p >= 40 && p < 50)) return 2'b11;
    return 2'b01;
  endfunction

  function automatic logic [W-1:0] exp_val(int p);
    logic [1:0] c;
    c = exp_code(p);
    if (c == 2'b00) return SV;
    if (c == 2'b11) return WV;
    return BV;
  endfunction

  function automatic string req_of(int p);
    logic [1:0] c;
    c = exp_code(p);
    if (c == 2'b00) return "R3";
    if (c == 2'b11) return "R4";
    return "R5";
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // After an edge counted as j since enable, compare against the pattern.
  task automatic check_pos(int j, string tag);
    int p;
    p = (j / DIV) % LEN;
    check({req_of(p), " code ", tag}, int'(level_code), int'(exp_code(p)));
    check({req_of(p), " value ", tag}, int'(video_out), int'(exp_val(p)));
    check({"R2 strobe ", tag}, int'(line_start),
          ((j % (DIV * LEN)) == 0) ? 1 : 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tp_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      live_video = W'(8'hF0 + i);
      @(posedge clk); #1;
      check("R1 code", int'(level_code), 1);
      check("R1 value", int'(video_out), 0);
      check("R1 strobe", int'(line_start), 0);
    end
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check_pos(0, "R9 first after reset");
  endtask

  task automatic t_pattern_lines();
    @(negedge clk);
    tp_en = 1'b0;
    @(negedge clk);
    tp_en = 1'b1;
    for (int j = 0; j < 3 * DIV * LEN; j++) begin
      @(posedge clk); #1;
      check_pos(j, (j >= DIV * LEN) ? "R6 repeat" : "line0");
      @(negedge clk);
      // R7: live input keeps changing while the pattern is shown
      live_video = W'(j * 37 + 11);
    end
  endtask

  task automatic t_passthrough();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      tp_en = 1'b0;
      live_video = W'(8'hA5 ^ (i * 29));
      @(posedge clk); #1;
      check("R8 code", int'(level_code), 1);
      check("R8 strobe", int'(line_start), 0);
      check("R8 value", int'(video_out), int'(W'(8'hA5 ^ (i * 29))));
    end
  endtask

  task automatic t_restart_mid_line();
    @(negedge clk);
    tp_en = 1'b1;
    for (int j = 0; j < 45; j++) begin
      @(posedge clk); #1;
      check_pos(j, "pre-restart");
      @(negedge clk);
    end
    tp_en = 1'b0;
    @(negedge clk);
    tp_en = 1'b1;
    for (int j = 0; j < 14; j++) begin
      @(posedge clk); #1;
      check_pos(j, "R9 restart");
      @(negedge clk);
      live_video = W'(j * 5);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pattern_lines();
    t_passthrough();
    t_restart_mid_line();
    t_passthrough();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule